// File: doc/BRIEF.md
# Double-Data-Rate Ethernet Receive Byte Assembler

This block sits directly behind the pins of a reduced-pin Ethernet receive port. Four data lines and one control line each carry two samples per clock period: one is taken on the rising edge of the receive clock and one on the falling edge. The block captures both halves and joins the two nibbles into a byte. It decodes the control line into a valid flag and an error flag. Byte and flags are presented together, registered on the rising edge of the receive clock.

The same logic serves nominal receive clock periods of 8 ns, 40 ns and 400 ns, which correspond to 1000, 100 and 10 Mbps. The clock arrives already skewed against data and control by the board or the PHY, so the block has no delay element of its own. The falling-edge capture is a plain negative-edge register, which a synthesis flow can map onto a dual-edge input flop.

Top module: `rgmii_rx_ddr`

## Requirements
- R1: The data nibble sampled at a rising edge of `rx_clk` becomes bits 3:0 of `rx_byte`.
- R2: The data nibble sampled at the falling edge that follows the same rising edge becomes bits 7:4 of `rx_byte`.
- R3: The control level sampled at a rising edge becomes `rx_valid` (1 = byte valid).
- R4: The control level sampled at the following falling edge is driven on `rx_error` unchanged. It is not combined with the valid sample, and it passes through even when valid is 0.
- R5: Byte and flags captured in one clock period appear together after the next rising edge and stay stable for one full period.
- R6: While `rx_valid` is 0, `rx_byte` is 0x00 whatever the data lines carry.
- R7: `rst` is synchronous and active high. While it is sampled high, all outputs are 0. In the first period after it is released, the outputs are also 0, because the captured halves were cleared.
- R8: Consecutive periods of valid data produce one byte per period with no gap and no mixing of halves between periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock, already delayed relative to data and control |
| rst | input | 1 | Synchronous active-high reset |
| rx_nib | input | 4 | Double-rate data lines |
| rx_ctl | input | 1 | Double-rate control line: valid on rising edge, error on falling edge |
| rx_byte | output | 8 | Assembled byte, low nibble from the rising edge |
| rx_valid | output | 1 | Byte valid flag |
| rx_error | output | 1 | Receive error flag |

## Verification
A fault in the rising-edge or falling-edge capture shows up as a wrong nibble or a wrong flag at the ports exactly one rising edge after the affected period. Swapped nibble order or a valid/error mix-up is therefore seen on the first byte whose halves differ. A stale or uncleared half surfaces in the zero period that must follow reset, or as a byte that mixes two neighbouring periods in back-to-back traffic.

// File: rtl/rgmii_rx_ddr.sv
module rgmii_rx_ddr #(
  parameter int NIB_W = 4
) (
  input  logic                 rx_clk,
  input  logic                 rst,
  input  logic [NIB_W-1:0]     rx_nib,
  input  logic                 rx_ctl,
  output logic [2*NIB_W-1:0]   rx_byte,
  output logic                 rx_valid,
  output logic                 rx_error
);

  localparam int BYTE_W = 2 * NIB_W;

  logic [NIB_W-1:0] lo_q, hi_q;
  logic             dv_q, er_q;

  always_ff @(posedge rx_clk) begin
    if (rst) begin
      lo_q <= '0;
      dv_q <= 1'b0;
    end else begin
      lo_q <= rx_nib;
      dv_q <= rx_ctl;
    end
  end

  always_ff @(negedge rx_clk) begin
    if (rst) begin
      hi_q <= '0;
      er_q <= 1'b0;
    end else begin
      hi_q <= rx_nib;
      er_q <= rx_ctl;
    end
  end

  always_ff @(posedge rx_clk) begin
    if (rst) begin
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
    end else begin
      rx_byte  <= dv_q ? {hi_q, lo_q} : {BYTE_W{1'b0}};
      rx_valid <= dv_q;
      rx_error <= er_q;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge rx_clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r6_zero_when_idle: assert property (@(posedge rx_clk) disable iff (rst)
    !rx_valid |-> rx_byte == '0);

  a_r3_valid_from_rise: assert property (@(posedge rx_clk) disable iff (rst)
    warm >= 2'd2 |-> rx_valid == $past(rx_ctl, 2));

  a_r1_low_nibble: assert property (@(posedge rx_clk) disable iff (rst)
    (warm >= 2'd2 && rx_valid) |-> rx_byte[NIB_W-1:0] == $past(rx_nib, 2));

  a_r2_high_nibble: assert property (@(posedge rx_clk) disable iff (rst)
    (warm >= 2'd1 && rx_valid) |-> rx_byte[BYTE_W-1:NIB_W] == $past(hi_q));

endmodule

// File: tb/rgmii_rx_ddr_tb.sv
module rgmii_rx_ddr_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] nib = '0;
  logic       ctl = 1'b0;
  logic [7:0] byte_o;
  logic       dv_o, er_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rgmii_rx_ddr dut_i (
    .rx_clk(clk), .rst(rst), .rx_nib(nib), .rx_ctl(ctl),
    .rx_byte(byte_o), .rx_valid(dv_o), .rx_error(er_o)
  );

  // {dv, er, hi, lo}
  localparam logic [9:0] VEC [12] = '{
    {1'b1, 1'b0, 4'h5, 4'hA},
    {1'b1, 1'b0, 4'hD, 4'h5},
    {1'b1, 1'b0, 4'h0, 4'hF},
    {1'b1, 1'b0, 4'hF, 4'h0},
    {1'b1, 1'b1, 4'h3, 4'hC},
    {1'b0, 1'b1, 4'hE, 4'h7},
    {1'b0, 1'b0, 4'h9, 4'h6},
    {1'b1, 1'b0, 4'h1, 4'h2},
    {1'b1, 1'b1, 4'h8, 4'h4},
    {1'b0, 1'b0, 4'hF, 4'hF},
    {1'b1, 1'b0, 4'h7, 4'hE},
    {1'b1, 1'b0, 4'hB, 4'h4}
  };

  task automatic beat(input logic [9:0] v);
    @(negedge clk); #1;
    nib = v[3:0]; ctl = v[9];
    @(posedge clk); #1;
    nib = v[7:4]; ctl = v[8];
  endtask

  task automatic check(input string req, input logic [7:0] eb,
                       input logic ev, input logic ee);
    checks++;
    if (byte_o !== eb || dv_o !== ev || er_o !== ee) begin
      errors++;
      $display("FAIL %s: got byte=%h dv=%b er=%b, expected byte=%h dv=%b er=%b",
               req, byte_o, dv_o, er_o, eb, ev, ee);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [9:0] v);
    return v[9] ? v[7:0] : 8'h00;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset state", 8'h00, 1'b0, 1'b0);

    // release reset; first period after release must be zero (R7)
    @(negedge clk); #1; rst = 1'b0; nib = 4'h1; ctl = 1'b1;
    @(posedge clk); #1; nib = 4'h2; ctl = 1'b0;
    check("R7 first period after release", 8'h00, 1'b0, 1'b0);
    beat({1'b0, 1'b0, 4'h0, 4'h0});
    check("R1 R2 R3 first byte after release", 8'h21, 1'b1, 1'b0);

    // back-to-back vectors: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 12; i++) begin
      beat(VEC[i]);
      if (i > 0)
        check("R1 R2 R3 R4 R6 R8 vector stream", exp_byte(VEC[i-1]),
              VEC[i-1][9], VEC[i-1][8]);
    end
    beat(10'h000);
    check("R8 last vector", exp_byte(VEC[11]), VEC[11][9], VEC[11][8]);

    // R5: hold for full period: sample again just before next rising edge
    beat({1'b1, 1'b1, 4'hC, 4'h3});
    @(negedge clk); #1.2;
    check("R5 stable across period", 8'h00, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R5 byte after next rising edge", 8'hC3, 1'b1, 1'b1);

    // R4: error alone with valid low, not xor
    beat({1'b0, 1'b1, 4'hA, 4'hA});
    beat(10'h000);
    check("R4 error passes with valid low", 8'h00, 1'b0, 1'b1);

    // R6: data lines busy, valid low
    beat({1'b0, 1'b0, 4'h6, 4'h9});
    beat(10'h000);
    check("R6 idle byte zero", 8'h00, 1'b0, 1'b0);

    // R7: reset mid-traffic clears everything
    beat({1'b1, 1'b0, 4'h4, 4'h4});
    @(negedge clk); #1; rst = 1'b1; nib = 4'h7; ctl = 1'b1;
    @(posedge clk); #1; nib = 4'h7; ctl = 1'b1;
    check("R7 outputs zero in reset", 8'h00, 1'b0, 1'b0);
    @(negedge clk); #1; rst = 1'b0; nib = 4'hB; ctl = 1'b1;
    @(posedge clk); #1; nib = 4'hE; ctl = 1'b1;
    check("R7 zero after mid-run release", 8'h00, 1'b0, 1'b0);
    beat(10'h000);
    check("R7 recovery byte", 8'hEB, 1'b1, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule